// File: doc/BRIEF.md
# Operand Address Generator

This block turns the operand bytes that follow an opcode into an effective address for a small 8-bit audio processor. After a mode request it reads one or two bytes from memory. Each read goes out at the current program counter, which then steps forward. When the last byte arrives the block presents the address, a bit index, and the advanced program counter, and raises a one-cycle completion strobe.

Three addressing forms are supported. The page-relative form takes one byte, which is moved up by 100h when the page-select flag is set. The full form combines two bytes, low first, into a 16-bit address. The bit form reads two bytes the same way and splits the resulting word into a 13-bit byte address (the low bits) and a 3-bit bit number (the top three bits). Memory reads use a request/valid handshake, so any number of wait cycles may occur.

Top module: `opaddr_gen`

## Requirements
- R1: After reset, and after a reset that cuts off an operation in progress, `busy`, `mem_req` and `done` are all low.
- R2: Mode code 2'b00 (page-relative) fetches one byte B. The result is `ea_out` = B, plus 0100h when `dp_flag` was high in the accept cycle. `bit_idx` is 0.
- R3: Mode code 2'b01 (full) fetches a low byte L and then a high byte H. The result is `ea_out` = {H, L}, with `bit_idx` 0. `dp_flag` has no effect in this mode.
- R4: Mode code 2'b10 (bit) fetches L and then H and forms W = {H, L}. The result is `ea_out` = W[12:0] zero-extended to 16 bits, and `bit_idx` = W[15:13]. Mode code 2'b11 gives the same result as 2'b01.
- R5: Byte k of an operation (k = 0, 1) is requested at `mem_addr` = `pc_in` + k. On completion, `pc_out` equals `pc_in` plus the number of bytes fetched.
- R6: Program counter arithmetic wraps from FFFFh to 0000h.
- R7: `mem_req` stays high and `mem_addr` stays unchanged until a cycle in which `mem_rvalid` is high. Each wait cycle delays completion by one cycle.
- R8: `done` is high for exactly one cycle, while the results are valid. The block is idle in the next cycle.
- R9: `req_valid`, and changes to `req_mode`, `pc_in` and `dp_flag`, are ignored while `busy` is high.
- R10: `mem_rvalid` is ignored while `mem_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an operation (taken only when idle) |
| req_mode | input | 2 | Addressing form: 00 page, 01 full, 10 bit, 11 as full |
| pc_in | input | 16 | Program counter at the first operand byte |
| dp_flag | input | 1 | Page-select flag, sampled on accept |
| busy | output | 1 | Operation in progress (including the done cycle) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion strobe |
| ea_out | output | 16 | Effective address |
| bit_idx | output | 3 | Bit number (bit form only, else 0) |
| pc_out | output | 16 | Program counter after the operand |

## Verification
The request is sampled at one rising edge, and `mem_req` is high from the next cycle on. Each byte needs one cycle plus its wait cycles. `done` therefore rises n·(w+1)+1 cycles after the accepting edge, where n is the byte count and w is the wait count per byte. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the accept, compares `mem_addr` with the expected byte address in every request cycle, and checks the results and the latency in the first cycle `done` is seen. In the cycle after that it confirms that `done` has dropped and the block is idle.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [1:0] {
        MODE_DIR = 2'b00,
        MODE_ABS = 2'b01,
        MODE_BIT = 2'b10,
        MODE_RSV = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LO   = 2'b01,
        ST_HI   = 2'b10,
        ST_DONE = 2'b11
    } state_e;

endpackage

// File: rtl/opaddr_pc_inc.sv
module opaddr_pc_inc #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] pc_i,
    output logic [AW-1:0] pc_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        pc_o = pc_i + ONE;
    end
endmodule

// File: rtl/opaddr_form.sv
module opaddr_form
    import opaddr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  mode_e         mode_i,
    input  logic          dp_i,
    input  logic [DW-1:0] lo_i,
    input  logic [DW-1:0] hi_i,
    output logic [AW-1:0] ea_o,
    output logic [BW-1:0] bit_o
);
    localparam int            LW        = AW - BW;
    localparam logic [AW-1:0] PAGE_STEP = AW'(1) << DW;
    localparam logic [AW-1:0] LOW_MASK  = (AW'(1) << LW) - AW'(1);

    logic [AW-1:0] word;
    logic [AW-1:0] page_ea;

    always_comb begin
        word    = AW'({hi_i, lo_i});
        page_ea = AW'(lo_i) + (dp_i ? PAGE_STEP : '0);
        ea_o    = word;
        bit_o   = '0;
        case (mode_i)
            MODE_DIR: ea_o = page_ea;
            MODE_BIT: begin
                ea_o  = word & LOW_MASK;
                bit_o = word[AW-1 -: BW];
            end
            default:  ea_o = word;
        endcase
    end
endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq
    import opaddr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  mode_e         mode_i,
    input  logic [AW-1:0] pc_i,
    input  logic          dp_i,
    input  logic          rvalid_i,
    input  logic [DW-1:0] rdata_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          done_o,
    output logic          busy_o,
    output mode_e         mode_o,
    output logic          dp_o,
    output logic [DW-1:0] lo_o,
    output logic [DW-1:0] hi_o,
    output logic [AW-1:0] pc_o
);
    typedef struct packed {
        state_e        state;
        mode_e         mode;
        logic          dp;
        logic [AW-1:0] pc;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        state: ST_IDLE, mode: MODE_DIR, dp: 1'b0,
        pc: '0, lo: '0, hi: '0
    };

    seq_t          seq_d, seq_q;
    logic [AW-1:0] pc_next;
    logic          fetching;

    opaddr_pc_inc #(.AW(AW)) u_pc_inc (
        .pc_i (seq_q.pc),
        .pc_o (pc_next)
    );

    always_comb begin
        fetching = (seq_q.state == ST_LO) || (seq_q.state == ST_HI);
        seq_d    = seq_q;
        case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state = ST_LO;
                    seq_d.mode  = mode_i;
                    seq_d.dp    = dp_i;
                    seq_d.pc    = pc_i;
                    seq_d.lo    = '0;
                    seq_d.hi    = '0;
                end
            end
            ST_LO: begin
                if (rvalid_i) begin
                    seq_d.lo    = rdata_i;
                    seq_d.pc    = pc_next;
                    seq_d.state = (seq_q.mode == MODE_DIR) ? ST_DONE : ST_HI;
                end
            end
            ST_HI: begin
                if (rvalid_i) begin
                    seq_d.hi    = rdata_i;
                    seq_d.pc    = pc_next;
                    seq_d.state = ST_DONE;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign mem_req_o  = fetching;
    assign mem_addr_o = seq_q.pc;
    assign done_o     = (seq_q.state == ST_DONE);
    assign busy_o     = (seq_q.state != ST_IDLE);
    assign mode_o     = seq_q.mode;
    assign dp_o       = seq_q.dp;
    assign lo_o       = seq_q.lo;
    assign hi_o       = seq_q.hi;
    assign pc_o       = seq_q.pc;

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && rvalid_i) |=> (pc_o == $past(mem_addr_o) + AW'(1)));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(mode_o) && $stable(dp_o)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_o && !busy_o) |=> ($stable(lo_o) && $stable(pc_o) || busy_o));
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    localparam int BW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_mode,
    input  logic [AW-1:0] pc_in,
    input  logic          dp_flag,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] ea_out,
    output logic [BW-1:0] bit_idx,
    output logic [AW-1:0] pc_out
);
    localparam int            LW       = AW - BW;
    localparam logic [AW-1:0] PAGE_END = AW'(1) << (DW + 1);

    mode_e         mode_q;
    logic          dp_q;
    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;

    opaddr_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (req_valid),
        .mode_i     (mode_e'(req_mode)),
        .pc_i       (pc_in),
        .dp_i       (dp_flag),
        .rvalid_i   (mem_rvalid),
        .rdata_i    (mem_rdata),
        .mem_req_o  (mem_req),
        .mem_addr_o (mem_addr),
        .done_o     (done),
        .busy_o     (busy),
        .mode_o     (mode_q),
        .dp_o       (dp_q),
        .lo_o       (lo_q),
        .hi_o       (hi_q),
        .pc_o       (pc_out)
    );

    opaddr_form #(.AW(AW), .DW(DW)) u_form (
        .mode_i (mode_q),
        .dp_i   (dp_q),
        .lo_i   (lo_q),
        .hi_i   (hi_q),
        .ea_o   (ea_out),
        .bit_o  (bit_idx)
    );

    // R4
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MODE_BIT) |-> (ea_out[AW-1:LW] == '0));

    // R4
    bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q != MODE_BIT) |-> (bit_idx == '0));

    // R2
    page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == MODE_DIR) |-> (ea_out < PAGE_END));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req && !done));
endmodule

// File: tb/opaddr_gen_bench.sv
module opaddr_gen_bench;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] pc;
        logic        dp;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [1:0]  wt;
        logic        stray;
        logic [15:0] ea;
        logic [2:0]  bi;
        logic [15:0] pc_end;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 16'h0200, 1'b0, 8'h34, 8'h00, 2'd0, 1'b0, 16'h0034, 3'd0, 16'h0201},
        '{2'b00, 16'h0300, 1'b1, 8'hF0, 8'h00, 2'd1, 1'b1, 16'h01F0, 3'd0, 16'h0301},
        '{2'b01, 16'h1000, 1'b1, 8'h78, 8'h56, 2'd0, 1'b0, 16'h5678, 3'd0, 16'h1002},
        '{2'b01, 16'h2000, 1'b0, 8'hCD, 8'hAB, 2'd2, 1'b1, 16'hABCD, 3'd0, 16'h2002},
        '{2'b10, 16'h4000, 1'b0, 8'h21, 8'hE3, 2'd0, 1'b0, 16'h0321, 3'd7, 16'h4002},
        '{2'b10, 16'h4100, 1'b0, 8'hFF, 8'h5F, 2'd1, 1'b0, 16'h1FFF, 3'd2, 16'h4102},
        '{2'b10, 16'h0010, 1'b1, 8'h00, 8'h00, 2'd0, 1'b0, 16'h0000, 3'd0, 16'h0012},
        '{2'b11, 16'h0500, 1'b0, 8'h11, 8'h22, 2'd0, 1'b0, 16'h2211, 3'd0, 16'h0502},
        '{2'b01, 16'hFFFF, 1'b0, 8'h9A, 8'hBC, 2'd0, 1'b0, 16'hBC9A, 3'd0, 16'h0001},
        '{2'b00, 16'hFFFF, 1'b1, 8'hFF, 8'h00, 2'd0, 1'b0, 16'h01FF, 3'd0, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [15:0] pc_in = '0;
    logic        dp_flag = 1'b0;
    logic        busy, mem_req, done;
    logic [15:0] mem_addr, ea_out, pc_out;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [2:0]  bit_idx;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opaddr_gen u_opaddr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .pc_in      (pc_in),
        .dp_flag    (dp_flag),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .ea_out     (ea_out),
        .bit_idx    (bit_idx),
        .pc_out     (pc_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic run_vec(input vec_t v, input int id);
        int nb, idx, wcnt, cyc, lat;
        bit got;
        logic [15:0] exp_ma;
        nb  = (v.mode == 2'b00) ? 1 : 2;
        lat = nb * (int'(v.wt) + 1) + 1;
        @(negedge clk);
        req_valid = 1'b1; req_mode = v.mode; pc_in = v.pc; dp_flag = v.dp;
        @(negedge clk);
        req_valid = 1'b0; req_mode = ~v.mode; pc_in = 16'h7777; dp_flag = ~v.dp;
        cyc = 1; idx = 0; wcnt = 0; got = 1'b0;
        while (!got && cyc < 40) begin
            if (done) begin
                got = 1'b1;
                mem_rvalid = 1'b0;
                req_valid  = 1'b0;
                chk(ea_out == v.ea, $sformatf("R2/R3/R4 ea vec%0d", id), 32'(ea_out), 32'(v.ea));
                chk(bit_idx == v.bi, $sformatf("R4 bit_idx vec%0d", id), 32'(bit_idx), 32'(v.bi));
                chk(pc_out == v.pc_end, $sformatf("R5/R6 pc_out vec%0d", id), 32'(pc_out), 32'(v.pc_end));
                chk(cyc == lat, $sformatf("R7/R8 latency vec%0d", id), 32'(cyc), 32'(lat));
            end else begin
                mem_rvalid = 1'b0;
                // R9: stray start request while busy
                req_valid = (v.stray && cyc == 2);
                req_mode  = 2'b10;
                if (mem_req) begin
                    exp_ma = v.pc + 16'(idx);
                    chk(mem_addr == exp_ma, $sformatf("R5/R7 mem_addr vec%0d", id),
                        32'(mem_addr), 32'(exp_ma));
                    if (wcnt < int'(v.wt)) begin
                        wcnt++;
                    end else begin
                        mem_rvalid = 1'b1;
                        mem_rdata  = (idx == 0) ? v.b0 : v.b1;
                        idx++;
                        wcnt = 0;
                    end
                end else begin
                    chk(1'b0, $sformatf("R7 mem_req dropped vec%0d", id), 32'(mem_req), 32'd1);
                end
                @(negedge clk);
                cyc++;
            end
        end
        if (!got) chk(1'b0, $sformatf("R8 no done vec%0d", id), 32'd0, 32'd1);
        @(negedge clk);
        chk(!done && !busy, $sformatf("R8 pulse end vec%0d", id), 32'({done, busy}), 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !done, "R1 reset state", 32'({busy, mem_req, done}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !done, "R1 after release", 32'({busy, mem_req, done}), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R10: read-valid pulses while idle must not start or disturb anything
        mem_rvalid = 1'b1; mem_rdata = 8'hAA;
        @(negedge clk);
        @(negedge clk);
        chk(!busy && !mem_req && !done, "R10 idle rvalid", 32'({busy, mem_req, done}), 32'd0);
        chk(pc_out == 16'h0000, "R10 pc_out kept", 32'(pc_out), 32'h0000);
        mem_rvalid = 1'b0;
        run_vec(VECS[2], 100);

        // R1: reset in the middle of a fetch
        req_valid = 1'b1; req_mode = 2'b01; pc_in = 16'h3000; dp_flag = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_req && mem_addr == 16'h3000, "R1 fetch started", 32'(mem_addr), 32'h3000);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req && !done, "R1 mid-op reset", 32'({busy, mem_req, done}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1 stays idle", 32'({busy, mem_req}), 32'd0);
        run_vec(VECS[4], 101);

        finish_run();
    end
endmodule